// File: doc/BRIEF.md
# Programmable interval / free-run timer channel

This block is a single timer channel driven from a simple synchronous register bus. Software programs a compare value and a mode bit while the channel is idle. It then fires a start trigger. The channel keeps running until a stop trigger arrives. A read-only status bit reports whether the channel is running, so software can poll it to confirm a stop.

There are two modes. In interval mode the counter is loaded with the compare value and counts down. It raises a one-clock interrupt each time it passes zero and reloads, so a compare of N−1 gives one interrupt every N clocks. In free-run mode the counter starts at zero and counts up, wrapping at all-ones. The interrupt pulses in the clock where the count equals the compare value, which lets software use the channel as a timestamp source or, by stopping it after the first interrupt, as a one-shot.

Bus reads are registered: read data appears the clock after the read enable. The counter width is a parameter, 32 by default. The bus data path is 32 bits wide and narrower fields are zero-extended on read.

Top module: `tmr_channel`

## Requirements
- R1: After reset the compare value, counter, mode bit, running status and interrupt are all zero, which selects interval mode.
- R2: A write to byte offset 0x14 with byte lane 0 enabled and data bit 0 set starts the channel, and the status bit (offset 0x10, bit 0) reads 1 from the next clock. Starting in interval mode loads the counter with the compare value. Starting in free-run mode clears the counter to 0.
- R3: A write to byte offset 0x18 with byte lane 0 enabled and data bit 0 set stops the channel from the next clock. The status bit then reads 0, the counter holds its value, and no interrupt fires while the channel is stopped.
- R4: In interval mode (control bit 1 = 0) with compare = N−1, the interrupt is a one-clock pulse. The first pulse comes N clocks after the start write is accepted, and pulses repeat every N clocks until the channel is stopped.
- R5: In free-run mode (control bit 1 = 1) the counter rises by one each clock. With a nonzero compare C, the interrupt pulses for exactly one clock, C clocks after the start write is accepted, in the clock where the counter equals C.
- R6: In free-run mode the counter wraps from all-ones to zero. With compare = 0 the interrupt pulses in the clock the wrap lands on zero, and at no other time.
- R7: The control register sits at offset 0x20 with the mode in bit 1 and reads back what was written. A write to it while the status bit is 1 is ignored.
- R8: The compare register at offset 0x00 is read/write, and each byte lane is written only when its strobe is set. The counter at offset 0x04 is read-only, and writes to it are ignored.
- R9: Reads of the start and stop offsets, and of unmapped offsets, return zero. Every read returns its data on the clock after the read enable.
- R10: The status register at offset 0x10 is read-only, and writes to it do not start or stop the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | One-clock interrupt pulse |

## Verification
The hardest event to reach from the ports is the free-run wrap. With a full 32-bit counter it would take billions of clocks. The bench therefore builds the channel with a 16-bit counter and waits through the whole wrap with compare at zero, checking that exactly one pulse lands on the clock the count returns to zero. The control-write lockout is the other hard case. It needs a write that arrives mid-run, so the bench sends it while interval interrupts are already firing and reads the mode back only after the channel has been stopped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  // byte offsets of the register file
  localparam logic [7:0] OFF_CMP   = 8'h00;
  localparam logic [7:0] OFF_CNT   = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_START = 8'h14;
  localparam logic [7:0] OFF_STOP  = 8'h18;
  localparam logic [7:0] OFF_CTRL  = 8'h20;

  // control bit 1 selects the counting mode
  localparam int CTRL_MODE_BIT = 1;

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_FREE     = 1'b1
  } tmr_mode_e;

  // merge write data into an old word under byte strobes
  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int i = 0; i < BE_W; i++) begin
      if (be[i]) res[i*8 +: 8] = new_w[i*8 +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              run_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              cmp_wr_o,
  output logic [CNT_W-1:0]  cmp_o,
  output tmr_mode_e         mode_o
);
  logic [CNT_W-1:0] cmp_q;
  tmr_mode_e        mode_q;
  logic             hit_cmp, hit_ctrl, hit_start, hit_stop;
  logic             ctrl_wr;
  logic [DATA_W-1:0] cmp_merged;

  assign hit_cmp   = we_i && (addr_i == ADDR_W'(OFF_CMP));
  assign hit_ctrl  = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign hit_start = we_i && (addr_i == ADDR_W'(OFF_START));
  assign hit_stop  = we_i && (addr_i == ADDR_W'(OFF_STOP));

  assign start_o  = hit_start && be_i[0] && wdata_i[0];
  assign stop_o   = hit_stop  && be_i[0] && wdata_i[0];
  assign ctrl_wr  = hit_ctrl  && be_i[0] && !run_i;
  assign cmp_wr_o = hit_cmp   && (|be_i);

  assign cmp_merged = merge_lanes(DATA_W'(cmp_q), wdata_i, be_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= MODE_INTERVAL;
    end else begin
      if (cmp_wr_o) cmp_q <= CNT_W'(cmp_merged);
      if (ctrl_wr)  mode_q <= tmr_mode_e'(wdata_i[CTRL_MODE_BIT]);
    end
  end

  assign cmp_o  = cmp_q;
  assign mode_o = mode_q;

  // R7: the mode is frozen while the channel runs
  a_r7_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctrl && run_i) |=> $stable(mode_q));

  // R8: compare only moves on a compare write
  a_r8_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_cmp |=> $stable(cmp_q));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  tmr_mode_e        mode_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic             run_q, irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fire;
  logic             advance;

  // interval: count down and reload at zero
  function automatic logic [CNT_W-1:0] step_interval(input logic [CNT_W-1:0] c,
                                                     input logic [CNT_W-1:0] cmp);
    return (c == '0) ? cmp : c - 1'b1;
  endfunction

  // free-run: count up with natural wrap
  function automatic logic [CNT_W-1:0] step_free(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  // event: interval expiry, or the next free-run count hitting compare
  function automatic logic event_due(input tmr_mode_e m,
                                     input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] cmp);
    if (m == MODE_INTERVAL) return c == '0;
    return step_free(c) == cmp;
  endfunction

  assign advance = run_q && !start_i && !stop_i;
  assign fire    = advance && event_due(mode_i, cnt_q, cmp_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= fire;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= (mode_i == MODE_INTERVAL) ? cmp_i : '0;
      end else if (run_q) begin
        cnt_q <= (mode_i == MODE_INTERVAL) ? step_interval(cnt_q, cmp_i)
                                           : step_free(cnt_q);
      end
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R2: a start sets the running state
  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> run_q);

  // R2: free-run start begins at zero
  a_r2_free_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i && mode_i == MODE_FREE) |=> (cnt_q == '0));

  // R3: a stop clears the running state
  a_r3_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !run_q);

  // R3: an idle counter does not move
  a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> $stable(cnt_q));

  // R4: expiry reloads the compare value
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && mode_i == MODE_INTERVAL && cnt_q == '0) |=> (cnt_q == $past(cmp_i)));

  // R3: no interrupt unless the channel was running
  a_r3_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(run_q));
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              re_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              run_i,
  input  tmr_mode_e         mode_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] sel_data;
  logic [DATA_W-1:0] rdata_q;
  logic              wo_hit;

  assign wo_hit = (addr_i == ADDR_W'(OFF_START)) || (addr_i == ADDR_W'(OFF_STOP));

  always_comb begin
    sel_data = '0;
    if      (addr_i == ADDR_W'(OFF_CMP))  sel_data = DATA_W'(cmp_i);
    else if (addr_i == ADDR_W'(OFF_CNT))  sel_data = DATA_W'(cnt_i);
    else if (addr_i == ADDR_W'(OFF_STAT)) sel_data = DATA_W'(run_i);
    else if (addr_i == ADDR_W'(OFF_CTRL)) sel_data[CTRL_MODE_BIT] = mode_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (re_i)  rdata_q <= sel_data;
  end

  assign rdata_o = rdata_q;

  // R9: trigger offsets read as zero
  a_r9_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (re_i && wo_hit) |=> (rdata_q == '0));

  // R9: read data holds between reads
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !re_i |=> $stable(rdata_q));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  logic             start_evt, stop_evt, cmp_wr_evt;
  logic             run;
  logic [CNT_W-1:0] cmp_val, cnt_val;
  tmr_mode_e        mode;

  tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
    .wdata_i(bus_wdata), .be_i(bus_be), .run_i(run),
    .start_o(start_evt), .stop_o(stop_evt), .cmp_wr_o(cmp_wr_evt),
    .cmp_o(cmp_val), .mode_o(mode)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .start_i(start_evt), .stop_i(stop_evt),
    .cmp_i(cmp_val), .mode_i(mode), .run_o(run), .cnt_o(cnt_val), .irq_o(irq_o)
  );

  tmr_rdmux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .re_i(bus_re),
    .cmp_i(cmp_val), .cnt_i(cnt_val), .run_i(run), .mode_i(mode),
    .rdata_o(bus_rdata)
  );

  // R4/R5: with a nonzero, unchanged compare the interrupt is one clock wide
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && cmp_val != '0 && !cmp_wr_evt) |=> !irq_o);

  // R10: a status write is neither a start nor a stop
  a_r10_stat_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_STAT)) |-> !(start_evt || stop_evt));
endmodule

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
  localparam int CNT_W = 16;
  localparam logic [31:0] MASK = 32'h0000_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  tmr_channel #(.ADDR_W(6), .CNT_W(CNT_W)) u_tmr_channel (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = b; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", 32'(irq_o), 0);
    rd(6'h00, v); chk("R1 compare", v, 0);
    rd(6'h04, v); chk("R1 counter", v, 0);
    rd(6'h10, v); chk("R1 status", v, 0);
    rd(6'h20, v); chk("R1 control", v, 0);
  endtask

  task automatic t_regs;
    logic [31:0] a, b;
    wr(6'h00, 32'hAABB_CCDD, 4'hF);
    wr(6'h00, 32'h1122_3344, 4'b0101);
    rd(6'h00, a); chk("R8 byte strobes", a, 32'hAA22_CC44 & MASK);
    rd(6'h04, a); wr(6'h04, 32'h55, 4'hF); rd(6'h04, b);
    chk("R8 counter write ignored", b, a);
    wr(6'h10, 32'h1, 4'hF); rd(6'h10, a); chk("R10 status write ignored", a, 0);
    rd(6'h14, a); chk("R9 start reads zero", a, 0);
    rd(6'h18, a); chk("R9 stop reads zero", a, 0);
    rd(6'h0C, a); chk("R9 unmapped reads zero", a, 0);
  endtask

  task automatic t_interval;
    logic [31:0] v;
    int bad = 0;
    wr(6'h00, 32'd4, 4'hF);
    wr(6'h20, 32'h0, 4'h1);
    wr(6'h14, 32'h1, 4'h1);
    for (int i = 0; i < 20; i++) begin
      if (i > 0) @(negedge clk);
      if (irq_o !== ((i > 0) && (i % 5 == 0))) bad++;
    end
    chk("R4 pulse every 5 clocks", 32'(bad), 0);
    rd(6'h10, v); chk("R2 status running", v, 1);
    wr(6'h20, 32'h2, 4'h1);
    wr(6'h18, 32'h1, 4'h1);
    rd(6'h10, v); chk("R3 status cleared", v, 0);
    rd(6'h20, v); chk("R7 control write ignored while running", v, 0);
  endtask

  task automatic t_free;
    logic [31:0] a, b;
    int bad = 0;
    wr(6'h00, 32'd6, 4'hF);
    wr(6'h20, 32'h2, 4'h1);
    rd(6'h20, a); chk("R7 control readback", a, 2);
    wr(6'h14, 32'h1, 4'h1);
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      if (irq_o !== (i == 6)) bad++;
    end
    chk("R5 single match pulse", 32'(bad), 0);
    rd(6'h04, a); rd(6'h04, b);
    chk("R5 up-count step", b - a, 2);
    wr(6'h18, 32'h1, 4'h1);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (irq_o !== 1'b0) bad++;
    end
    chk("R3 no interrupt when stopped", 32'(bad), 0);
    rd(6'h04, a); rd(6'h04, b);
    chk("R3 counter frozen", b, a);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    int bad = 0;
    int hits = 0;
    wr(6'h00, 32'd0, 4'hF);
    wr(6'h14, 32'h1, 4'h1);
    rd(6'h04, v); chk("R2 free start near zero", v, 1);
    for (int i = 3; i < 65540; i++) begin
      @(negedge clk);
      if (irq_o) hits++;
      if (irq_o !== (i == 65536)) bad++;
    end
    chk("R6 wrap pulse position", 32'(bad), 0);
    chk("R6 one pulse per wrap", 32'(hits), 1);
    wr(6'h18, 32'h1, 4'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_interval;
    t_free;
    t_wrap;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule